// File: doc/BRIEF.md
# MLT-3 Serial Line Encoder

This block turns a stream of fixed-length words into a three-level line code. An upstream framer offers a word through a valid/ready handshake. The encoder serializes the word one bit per baud, and a baud-rate enable marks each baud. A four-position phase machine steps once for every 1 bit and holds on every 0 bit. The output is the line level for each baud, written as a 2-bit signed value.

Words go out back to back with no gap between them. The upstream framer gives each word even parity, so every word should end, and the next word begin, with the line at one of the two neutral positions. The encoder checks this at each word boundary and raises either a boundary-good pulse or a phase-error pulse. If no word is offered when one is due, the encoder sends a word of zeros and sets a sticky underrun flag.

Top module: `mlt3_line_encoder`

## Requirements
- R1: After reset the level is 2'b00, word_ready, at_boundary, phase_error and underrun are all 0, and the phase machine sits at the neutral position that comes before +1. The first baud after reset sends one 0 bit and then loads the first word.
- R2: Each 1 bit moves the phase one step around the cycle neutral, +1, neutral, -1. The level is coded 2'b00 for neutral, 2'b01 for +1 and 2'b11 for -1. The level appears in the clock cycle that follows the baud that sent the bit.
- R3: A 0 bit leaves the phase and the level unchanged.
- R4: Each word is WORD_W bits long and is sent most significant bit first. Words follow one another with no idle baud between them. word_ready is high only during a baud that sends the last bit of the current word, and the next word is taken on that baud.
- R5: After each baud that sends the last bit of a word, at_boundary pulses for one cycle if the phase is then at a neutral position (0° or 180°).
- R6: After each baud that sends the last bit of a word, phase_error pulses for one cycle if the phase is then at +1 or -1. at_boundary and phase_error are never high together.
- R7: If word_valid is low on a load baud, an all-zeros word is sent in place of data and underrun rises. underrun then stays high until reset.
- R8: In a cycle where baud_en is low, the level, the phase and the bit position do not change, word_ready is low, and both boundary pulses are low afterwards.

Ports and their widths are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_en | input | 1 | High for one cycle per baud |
| word_data | input | WORD_W | Word offered by the framer |
| word_valid | input | 1 | word_data holds a word |
| word_ready | output | 1 | The word is taken on this cycle |
| level | output | 2 | Line level: 00 neutral, 01 +1, 11 -1 |
| at_boundary | output | 1 | Pulse: the word ended at a neutral phase |
| phase_error | output | 1 | Pulse: the word ended at a non-neutral phase |
| underrun | output | 1 | Sticky: a zero word was sent because no word was offered |

## Verification
The hardest state to reach is a boundary where the phase is off neutral. It also has to be the 180° neutral position, which is just as valid. The stimulus sends words with every count of ones from 0 to 20, followed by a long series of hashed words, so the line passes through both neutral positions and through both non-neutral ones at word ends. Breaks in the valid signal, timed across load bauds, place all-zero underrun words between data words. The baud enable comes in an irregular pattern, so the hold behaviour is exercised both in the middle of words and on load bauds.

// File: rtl/mlt3_line_encoder.sv
module mlt3_line_encoder #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_en,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic [1:0]        level,
  output logic              at_boundary,
  output logic              phase_error,
  output logic              underrun
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;
  logic [1:0]        phase;

  wire       last_bit = (bit_idx == LAST_IDX);
  wire [1:0] phase_nx = phase + {1'b0, shreg[WORD_W-1]};

  assign word_ready = baud_en & last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg       <= '0;
      bit_idx     <= LAST_IDX;
      phase       <= 2'd0;
      level       <= 2'b00;
      at_boundary <= 1'b0;
      phase_error <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      at_boundary <= 1'b0;
      phase_error <= 1'b0;
      if (baud_en) begin
        phase <= phase_nx;
        level <= phase_nx[0] ? {phase_nx[1], 1'b1} : 2'b00;
        if (last_bit) begin
          shreg       <= word_valid ? word_data : '0;
          underrun    <= underrun | ~word_valid;
          bit_idx     <= '0;
          at_boundary <= ~phase_nx[0];
          phase_error <= phase_nx[0];
        end else begin
          shreg   <= shreg << 1;
          bit_idx <= bit_idx + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mlt3_line_encoder_chk.sv
module mlt3_line_encoder_chk #(
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              baud_en,
  input logic [WORD_W-1:0] word_data,
  input logic              word_valid,
  input logic              word_ready,
  input logic [1:0]        level,
  input logic              at_boundary,
  input logic              phase_error,
  input logic              underrun
);

  p_level_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b10);

  p_no_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |=> !((($past(level) == 2'b01) && (level == 2'b11)) ||
                  (($past(level) == 2'b11) && (level == 2'b01))));

  p_ready_on_baud_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> baud_en);

  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_boundary && phase_error));

  p_boundary_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ready |=> !at_boundary && !phase_error);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  p_underrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_ready && !word_valid) && !underrun |=> !underrun);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_en |=> $stable(level));

endmodule

bind mlt3_line_encoder mlt3_line_encoder_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/mlt3_line_encoder_bench.sv
module mlt3_line_encoder_bench;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         baud_en = 1'b0;
  logic [W-1:0] word_data = '0;
  logic         word_valid = 1'b0;
  logic         word_ready;
  logic [1:0]   level;
  logic         at_boundary;
  logic         phase_error;
  logic         underrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mlt3_line_encoder #(.WORD_W(W)) u_mlt3_line_encoder (.*);

  logic [W-1:0] m_sh;
  int m_cnt, m_ph, widx;
  bit m_under;

  function automatic logic [W-1:0] word_of(int i);
    logic [31:0] h;
    if (i <= W) return W'((64'd1 << i) - 1);
    h = 32'(i) * 32'h9E3779B1;
    h = h ^ (h >> 13) ^ (32'(i) << 7);
    return h[W-1:0];
  endfunction

  function automatic logic [1:0] lvl_of(int ph);
    case (ph)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(bit be, bit vld);
    bit last, eb, ee;
    @(negedge clk);
    baud_en = be;
    word_valid = vld;
    word_data = vld ? word_of(widx) : '0;
    last = be && (m_cnt == W - 1);
    eb = 0; ee = 0;
    #1;
    chk(be ? "R4 ready" : "R8 ready", int'(word_ready), int'(last));
    if (be) begin
      m_ph = (m_ph + int'(m_sh[W-1])) % 4;
      if (last) begin
        if (vld) begin m_sh = word_of(widx); widx++; end
        else begin m_sh = '0; m_under = 1; end
        m_cnt = 0;
        eb = (m_ph % 2) == 0;
        ee = !eb;
      end else begin
        m_sh = m_sh << 1;
        m_cnt++;
      end
    end
    @(posedge clk);
    #1;
    chk(be ? "R2/R3 level" : "R8 level hold", int'(level), int'(lvl_of(m_ph)));
    chk("R5 at_boundary", int'(at_boundary), int'(eb));
    chk("R6 phase_error", int'(phase_error), int'(ee));
    chk("R7 underrun", int'(underrun), int'(m_under));
  endtask

  initial begin
    m_sh = '0; m_cnt = W - 1; m_ph = 0; widx = 0; m_under = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 level", int'(level), 0);
    chk("R1 flags", int'({at_boundary, phase_error, underrun}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000 && widx < 80; cyc++) begin
      bit be, vld;
      be  = (cyc % 7 != 3) && (cyc % 11 != 5);
      vld = !((cyc >= 900 && cyc < 960) || (cyc >= 1500 && cyc < 1530));
      tick(be, vld);
    end
    chk("R4 words consumed", widx >= 80 ? 1 : 0, 1);
    chk("R7 underrun seen", int'(underrun), 1);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule